// File: doc/BRIEF.md
# I2C Master START Arbiter

This block decides when an I2C master may put a START condition on the bus, and it checks that the START actually happened. Software sets a start request. The block then waits until no other master owns the bus and SCL is released. It pulls SDA low while SCL stays high, and it waits until the START is seen on the synchronised lines fed back from the bus. It keeps SDA low for a programmable number of clocks, drives SCL low for one cycle, and then hands the lines to the byte engine. The START is confirmed from what is seen on the bus, not assumed from what was driven.

The block tracks bus ownership by decoding START and STOP conditions on the resynchronised SDA and SCL lines. If a request arrives while a byte is in flight, the block holds it until the byte has ended. It then issues a repeated START, even though the bus is marked in use by this master. An optional timeout limits how long a request may wait. On expiry the block sets a flag, drops the request, aborts the current transfer and returns to idle. The start-detected and timeout flags are sticky and are cleared by writing 1. Each flag can drive the interrupt output through its own enable.

Top module: `i2c_start_arb`

## Requirements
- R1: After reset, every output is 0: both line drives, the request, bus-in-use, transfer-busy, both flags and the interrupt.
- R2: SDA and SCL each pass through a two-flop synchroniser. On the synchronised lines, SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START sets `busInUse` and `startFlag`. A STOP clears `busInUse`. Any other SDA movement changes neither.
- R3: While `busInUse` is 1 or the synchronised SCL is low, SDA is not driven for a new START. Once the bus frees, the pending request goes ahead.
- R4: A START is generated as follows. SDA is driven low. When the block sees its own START, it clears `startReq`. SDA stays low for HOLD_CYC further clocks. `sclDrvLow` is then 1 for exactly one clock, together with `sdaDrvLow`, and both lines are then released. `xferBusy` becomes 1.
- R5: `startReq` clears only when the START is sensed on the bus, when the timeout expires, or when `ctrlEn` is 0. If SDA cannot fall, the block keeps driving and keeps the request pending.
- R6: The timeout field `toMode` selects the timeout length: 1 gives 2^10 clocks, 2 gives 2^12 and 3 gives 2^14. For a request made with no byte in flight, `timeoutFlag` becomes visible on the clock that is 2^N+1 edges after the edge that accepts `startWr`. At the same time `startReq` clears and both drives are released.
- R7: With `toMode` = 0, a request waits indefinitely and `timeoutFlag` never sets.
- R8: A request made while `bitPos` is nonzero (a byte has started) is held without driving until `bitPos` returns to 0. The timeout count starts only at that point.
- R9: While `xferBusy` is 1 and SCL is high, a request issues a repeated START even though `busInUse` is 1.
- R10: A timeout clears `xferBusy`, which aborts the current transfer. A STOP also clears it.
- R11: `startFlag` and `timeoutFlag` stay set until the matching clear input is pulsed. If a flag is set and cleared in the same clock, the set wins.
- R12: `irq` = (`startFlag` and `ieStart`) or (`timeoutFlag` and `ieTimeout`).
- R13: Setting `ctrlEn` to 0 clears `busInUse`, `startReq` and `xferBusy`, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlEn | input | 1 | Controller enable |
| toMode | input | 2 | Timeout select (0 off, 1/2/3 = 2^10/2^12/2^14 clocks) |
| startWr | input | 1 | Pulse that sets the start request |
| ieStart | input | 1 | Interrupt enable for the start-detected flag |
| ieTimeout | input | 1 | Interrupt enable for the timeout flag |
| clrStart | input | 1 | Write-1 clear of the start-detected flag |
| clrTimeout | input | 1 | Write-1 clear of the timeout flag |
| bitPos | input | 4 | Bit index of the byte in flight, 0 when no byte is active |
| sdaIn | input | 1 | SDA level seen on the bus |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaDrvLow | output | 1 | Pull SDA low |
| sclDrvLow | output | 1 | Pull SCL low |
| startReq | output | 1 | Start request pending |
| busInUse | output | 1 | A START has been seen with no STOP since |
| xferBusy | output | 1 | This master owns a transfer |
| startFlag | output | 1 | Sticky START-detected flag |
| timeoutFlag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- SCL is never pulled low without SDA also being held low, and the SCL pulse lasts one clock.
- No new SDA drive begins while another master owns the bus, unless this master already owns it.
- A request can only disappear together with a start or timeout flag, or with the enable low.
- Disabling the block clears the ownership state.

Only the bench scenarios can show the timing behaviour. These cover the exact timeout lengths for each mode, the deferral of a mid-byte request until the byte ends, the repeated START in an owned transfer, and a request that is never confirmed because SDA is pinned low.

// File: rtl/i2c_start_pkg.sv
`timescale 1ns/1ps
package i2c_start_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_WAIT,
    ST_DRIVE,
    ST_HOLD,
    ST_LOW
  } startState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic toRun;
    logic holdRun;
    logic reqClr;
    logic xferSet;
  } ctlStrobe_t;

  // status returned by the datapath
  typedef struct packed {
    logic startDet;
    logic busBusy;
    logic sclHigh;
    logic toExpire;
    logic holdDone;
    logic startReq;
    logic xferBusy;
  } dpStatus_t;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineCur,
  output logic linePrev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], lineIn};
  end

  assign lineCur  = pipe[STAGES-1];
  assign linePrev = pipe[STAGES];
endmodule

// File: rtl/i2c_start_dp.sv
`timescale 1ns/1ps
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int TO_BASE     = 10,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlEn,
  input  logic       startWr,
  input  logic [1:0] toMode,
  input  logic       clrStart,
  input  logic       clrTimeout,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  ctlStrobe_t strb,
  output dpStatus_t  stat,
  output logic       busInUse,
  output logic       startFlag,
  output logic       timeoutFlag
);
  localparam int CNT_W  = TO_BASE + 4;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'((1 << TO_BASE) - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'((1 << (TO_BASE + 2)) - 1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'((1 << (TO_BASE + 4)) - 1);

  logic [1:0] rawLines, curLines, prevLines;
  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (rawLines[g]),
      .lineCur (curLines[g]),
      .linePrev(prevLines[g])
    );
  end

  logic sdaCur, sdaPrev, sclCur, sclPrev;
  assign sdaCur  = curLines[0];
  assign sdaPrev = prevLines[0];
  assign sclCur  = curLines[1];
  assign sclPrev = prevLines[1];

  logic startDet, stopDet, sclStableHigh;
  assign sclStableHigh = sclCur & sclPrev;
  assign startDet = sclStableHigh & sdaPrev & ~sdaCur;
  assign stopDet  = sclStableHigh & ~sdaPrev & sdaCur;

  // timeout counter
  logic [CNT_W-1:0] toCnt, limitM1;
  logic toExpire;
  always_comb begin
    unique case (toMode)
      2'd1:    limitM1 = LIM1;
      2'd2:    limitM1 = LIM2;
      default: limitM1 = LIM3;
    endcase
  end
  assign toExpire = strb.toRun && (toMode != 2'd0) && (toCnt >= limitM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toCnt <= '0;
    else if (strb.toRun && (toMode != 2'd0) && !toExpire) toCnt <= toCnt + 1'b1;
    else toCnt <= '0;
  end

  // hold counter for SDA-low time after the START
  logic [HOLD_W-1:0] holdCnt;
  logic holdDone;
  assign holdDone = strb.holdRun && (holdCnt == HOLD_W'(HOLD_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdCnt <= '0;
    else if (strb.holdRun) holdCnt <= holdCnt + 1'b1;
    else                   holdCnt <= '0;
  end

  // bus ownership, request and transfer state
  logic startReqQ, xferBusyQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busInUse  <= 1'b0;
      startReqQ <= 1'b0;
      xferBusyQ <= 1'b0;
    end else if (!ctrlEn) begin
      busInUse  <= 1'b0;
      startReqQ <= 1'b0;
      xferBusyQ <= 1'b0;
    end else begin
      if (startDet)     busInUse <= 1'b1;
      else if (stopDet) busInUse <= 1'b0;

      if (strb.reqClr || toExpire) startReqQ <= 1'b0;
      else if (startWr)            startReqQ <= 1'b1;

      if (strb.xferSet)              xferBusyQ <= 1'b1;
      else if (toExpire || stopDet)  xferBusyQ <= 1'b0;
    end
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag   <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      if (startDet)      startFlag <= 1'b1;
      else if (clrStart) startFlag <= 1'b0;
      if (toExpire)        timeoutFlag <= 1'b1;
      else if (clrTimeout) timeoutFlag <= 1'b0;
    end
  end

  assign stat.startDet = startDet;
  assign stat.busBusy  = busInUse | ~sclCur;
  assign stat.sclHigh  = sclCur;
  assign stat.toExpire = toExpire;
  assign stat.holdDone = holdDone;
  assign stat.startReq = startReqQ;
  assign stat.xferBusy = xferBusyQ;
endmodule

// File: rtl/i2c_start_ctl.sv
`timescale 1ns/1ps
module i2c_start_ctl
  import i2c_start_pkg::*;
#(
  parameter int BITPOS_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlEn,
  input  logic [BITPOS_W-1:0] bitPos,
  input  dpStatus_t           stat,
  output ctlStrobe_t          strb,
  output logic                drvSda,
  output logic                drvScl
);
  startState_e state, stateNxt;
  logic byteMid, busFree;

  assign byteMid = (bitPos != '0);
  // a repeated START is allowed on a bus this master already owns
  assign busFree = !stat.busBusy || (stat.xferBusy && stat.sclHigh);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (stat.startReq) stateNxt = byteMid ? ST_DEFER : ST_WAIT;
      ST_DEFER: if (!byteMid) stateNxt = ST_WAIT;
      ST_WAIT: begin
        if (stat.toExpire) stateNxt = ST_IDLE;
        else if (busFree)  stateNxt = ST_DRIVE;
      end
      ST_DRIVE: begin
        if (stat.toExpire)      stateNxt = ST_IDLE;
        else if (stat.startDet) stateNxt = ST_HOLD;
      end
      ST_HOLD:  if (stat.holdDone) stateNxt = ST_LOW;
      ST_LOW:   stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
    if (!ctrlEn) stateNxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign strb.toRun   = (state == ST_WAIT) || (state == ST_DRIVE);
  assign strb.holdRun = (state == ST_HOLD);
  assign strb.reqClr  = (state == ST_DRIVE) && stat.startDet;
  assign strb.xferSet = (state == ST_LOW);
  assign drvSda = (state == ST_DRIVE) || (state == ST_HOLD) || (state == ST_LOW);
  assign drvScl = (state == ST_LOW);
endmodule

// File: rtl/i2c_start_arb.sv
`timescale 1ns/1ps
module i2c_start_arb
  import i2c_start_pkg::*;
#(
  parameter int TO_BASE     = 10,
  parameter int HOLD_CYC    = 4,
  parameter int BITPOS_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlEn,
  input  logic [1:0]          toMode,
  input  logic                startWr,
  input  logic                ieStart,
  input  logic                ieTimeout,
  input  logic                clrStart,
  input  logic                clrTimeout,
  input  logic [BITPOS_W-1:0] bitPos,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaDrvLow,
  output logic                sclDrvLow,
  output logic                startReq,
  output logic                busInUse,
  output logic                xferBusy,
  output logic                startFlag,
  output logic                timeoutFlag,
  output logic                irq
);
  ctlStrobe_t strb;
  dpStatus_t  stat;

  i2c_start_ctl #(.BITPOS_W(BITPOS_W)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .ctrlEn(ctrlEn),
    .bitPos(bitPos),
    .stat  (stat),
    .strb  (strb),
    .drvSda(sdaDrvLow),
    .drvScl(sclDrvLow)
  );

  i2c_start_dp #(
    .TO_BASE    (TO_BASE),
    .HOLD_CYC   (HOLD_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEn     (ctrlEn),
    .startWr    (startWr),
    .toMode     (toMode),
    .clrStart   (clrStart),
    .clrTimeout (clrTimeout),
    .sdaIn      (sdaIn),
    .sclIn      (sclIn),
    .strb       (strb),
    .stat       (stat),
    .busInUse   (busInUse),
    .startFlag  (startFlag),
    .timeoutFlag(timeoutFlag)
  );

  assign startReq = stat.startReq;
  assign xferBusy = stat.xferBusy;
  assign irq = (startFlag & ieStart) | (timeoutFlag & ieTimeout);
endmodule

// File: rtl/i2c_start_arb_chk.sv
`timescale 1ns/1ps
module i2c_start_arb_chk (
  input logic clk,
  input logic rstN,
  input logic ctrlEn,
  input logic sdaDrvLow,
  input logic sclDrvLow,
  input logic startReq,
  input logic busInUse,
  input logic xferBusy,
  input logic startFlag,
  input logic timeoutFlag
);
  // R4: SCL is pulled low only while SDA is held low
  p_scl_with_sda_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclDrvLow |-> sdaDrvLow);

  // R4: the SCL pulse lasts one clock
  p_scl_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclDrvLow |=> !sclDrvLow);

  // R3 / R9: a new SDA drive starts only on a free or owned bus
  p_no_drive_when_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> (!$past(busInUse) || $past(xferBusy)));

  // R5: the request disappears only with a flag or the enable low
  p_req_drop_reason_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startReq) |-> (startFlag || timeoutFlag || !$past(ctrlEn)));

  // R6: expiry drops the request
  p_timeout_clears_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> !startReq);

  // R13: disable clears ownership state
  p_disable_clears_r13: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (!busInUse && !startReq && !xferBusy));
endmodule

bind i2c_start_arb i2c_start_arb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlEn     (ctrlEn),
  .sdaDrvLow  (sdaDrvLow),
  .sclDrvLow  (sclDrvLow),
  .startReq   (startReq),
  .busInUse   (busInUse),
  .xferBusy   (xferBusy),
  .startFlag  (startFlag),
  .timeoutFlag(timeoutFlag)
);

// File: tb/test_i2c_start_arb.sv
`timescale 1ns/1ps
module test_i2c_start_arb;
  localparam int HOLD = 4;
  localparam int TOB  = 10;

  logic clk = 1'b0;
  logic rstN, ctrlEn, startWr, ieStart, ieTimeout, clrStart, clrTimeout;
  logic [1:0] toMode;
  logic [3:0] bitPos;
  logic tbSdaLow, tbSclLow;
  logic sdaDrvLow, sclDrvLow, startReq, busInUse, xferBusy, startFlag, timeoutFlag, irq;
  logic sda, scl;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign sda = !(sdaDrvLow || tbSdaLow);
  assign scl = !(sclDrvLow || tbSclLow);

  i2c_start_arb #(.TO_BASE(TOB), .HOLD_CYC(HOLD), .BITPOS_W(4), .SYNC_STAGES(2)) i_i2c_start_arb (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .toMode(toMode), .startWr(startWr),
    .ieStart(ieStart), .ieTimeout(ieTimeout), .clrStart(clrStart), .clrTimeout(clrTimeout),
    .bitPos(bitPos), .sdaIn(sda), .sclIn(scl), .sdaDrvLow(sdaDrvLow), .sclDrvLow(sclDrvLow),
    .startReq(startReq), .busInUse(busInUse), .xferBusy(xferBusy), .startFlag(startFlag),
    .timeoutFlag(timeoutFlag), .irq(irq)
  );

  // ---------------- reference model ----------------
  int mPhase, mCnt, mHold;   // 0 idle 1 defer 2 wait 3 drive 4 hold 5 low
  bit mReq, mBus, mXb, mSf, mTf;
  bit hSda[3], hScl[3];      // [0] first flop, [1] synced, [2] previous synced
  bit lnSda, lnScl;

  always @(negedge clk) begin
    #2;
    lnSda = sda;
    lnScl = scl;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mHold = 0;
      mReq = 0; mBus = 0; mXb = 0; mSf = 0; mTf = 0;
      for (int k = 0; k < 3; k++) begin hSda[k] = 1; hScl[k] = 1; end
    end else begin
      bit det, stp, expd, waiting, canGo;
      int lim, nPhase;
      det = hScl[1] && hScl[2] && hSda[2] && !hSda[1];
      stp = hScl[1] && hScl[2] && !hSda[2] && hSda[1];
      lim = (toMode == 0) ? 0 : (1 << (TOB + 2 * (int'(toMode) - 1)));
      waiting = (mPhase == 2) || (mPhase == 3);
      expd = waiting && (toMode != 0) && (mCnt >= lim - 1);
      canGo = hScl[1] && (!mBus || mXb);
      nPhase = mPhase;
      case (mPhase)
        0: if (mReq) nPhase = (bitPos != 0) ? 1 : 2;
        1: if (bitPos == 0) nPhase = 2;
        2: if (expd) nPhase = 0; else if (canGo) nPhase = 3;
        3: if (expd) nPhase = 0; else if (det) nPhase = 4;
        4: if (mHold == HOLD - 1) nPhase = 5;
        default: nPhase = 0;
      endcase
      if (!ctrlEn) nPhase = 0;
      mHold = (mPhase == 4) ? mHold + 1 : 0;
      mCnt = (waiting && toMode != 0 && !expd) ? mCnt + 1 : 0;
      if (!ctrlEn) begin
        mBus = 0; mReq = 0; mXb = 0;
      end else begin
        if (det) mBus = 1; else if (stp) mBus = 0;
        if (expd || (mPhase == 3 && det)) mReq = 0; else if (startWr) mReq = 1;
        if (mPhase == 5) mXb = 1; else if (expd || stp) mXb = 0;
      end
      if (det) mSf = 1; else if (clrStart) mSf = 0;
      if (expd) mTf = 1; else if (clrTimeout) mTf = 0;
      mPhase = nPhase;
      hSda[2] = hSda[1]; hSda[1] = hSda[0]; hSda[0] = lnSda;
      hScl[2] = hScl[1]; hScl[1] = hScl[0]; hScl[0] = lnScl;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      bit eSda, eScl, eIrq, miss;
      eSda = (mPhase >= 3);
      eScl = (mPhase == 5);
      eIrq = (mSf && ieStart) || (mTf && ieTimeout);
      miss = 0;
      total++;
      if (sdaDrvLow !== eSda) begin miss = 1; $display("FAIL R4 sdaDrvLow act=%0b exp=%0b t=%0t", sdaDrvLow, eSda, $time); end
      if (sclDrvLow !== eScl) begin miss = 1; $display("FAIL R4 sclDrvLow act=%0b exp=%0b t=%0t", sclDrvLow, eScl, $time); end
      if (busInUse !== mBus) begin miss = 1; $display("FAIL R2 busInUse act=%0b exp=%0b t=%0t", busInUse, mBus, $time); end
      if (startReq !== mReq) begin miss = 1; $display("FAIL R5 startReq act=%0b exp=%0b t=%0t", startReq, mReq, $time); end
      if (xferBusy !== mXb) begin miss = 1; $display("FAIL R10 xferBusy act=%0b exp=%0b t=%0t", xferBusy, mXb, $time); end
      if (startFlag !== mSf) begin miss = 1; $display("FAIL R11 startFlag act=%0b exp=%0b t=%0t", startFlag, mSf, $time); end
      if (timeoutFlag !== mTf) begin miss = 1; $display("FAIL R6 timeoutFlag act=%0b exp=%0b t=%0t", timeoutFlag, mTf, $time); end
      if (irq !== eIrq) begin miss = 1; $display("FAIL R12 irq act=%0b exp=%0b t=%0t", irq, eIrq, $time); end
      if (miss) bad++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drv();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv();
  endtask

  task automatic request();
    drv(); startWr = 1;
    drv(); startWr = 0;
  endtask

  task automatic pulseClr();
    drv(); clrStart = 1; clrTimeout = 1;
    drv(); clrStart = 0; clrTimeout = 0;
  endtask

  task automatic busStart();
    drv(); tbSdaLow = 1;
    idle(6);
  endtask

  task automatic busStop();
    drv(); tbSclLow = 1; tbSdaLow = 1;
    idle(3);
    tbSclLow = 0;
    idle(3);
    tbSdaLow = 0;
    idle(6);
  endtask

  task automatic waitSclPulse(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (sclDrvLow) seen = 1;
    end
    idle(3);
  endtask

  task automatic waitTimeout(input int lim, output int cyc);
    cyc = 0;
    while (!timeoutFlag && cyc < lim) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=finished");
    summary();
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    bit seen;
    int cyc;
    rstN = 0; ctrlEn = 1; startWr = 0; ieStart = 0; ieTimeout = 0;
    clrStart = 0; clrTimeout = 0; toMode = 0; bitPos = 0; tbSdaLow = 0; tbSclLow = 0;
    idle(4);
    rstN = 1;
    @(negedge clk);
    check({sdaDrvLow, sclDrvLow, startReq, busInUse, xferBusy, startFlag, timeoutFlag, irq} == 8'd0,
          "R1 reset outputs", {sdaDrvLow, sclDrvLow, startReq, busInUse, xferBusy, startFlag, timeoutFlag, irq}, 0);

    // R2: foreign START and STOP
    ieStart = 1;
    busStart();
    check(startFlag && busInUse, "R2 start seen", {startFlag, busInUse}, 3);
    check(irq == 1, "R12 irq from start flag", irq, 1);
    pulseClr();
    @(negedge clk);
    check(startFlag == 0, "R11 w1c start flag", startFlag, 0);
    check(busInUse == 1, "R11 clear leaves bus state", busInUse, 1);
    busStop();
    check(busInUse == 0, "R2 stop frees bus", busInUse, 0);
    ieStart = 0;

    // R4: own START on a free bus
    request();
    waitSclPulse(60, seen);
    check(seen, "R4 scl pulse after start", seen, 1);
    check(startReq == 0 && xferBusy == 1 && busInUse == 1, "R4 request done, transfer owned",
          {startReq, xferBusy, busInUse}, 3);
    pulseClr();

    // R8: mid-byte request is held back
    drv(); bitPos = 4'd4;
    request();
    idle(40);
    @(negedge clk);
    check(sdaDrvLow == 0 && startReq == 1, "R8 deferred during byte", {sdaDrvLow, startReq}, 1);
    bitPos = 4'd0;
    // R9: repeated START on own bus
    waitSclPulse(60, seen);
    check(seen, "R9 repeated start issued", seen, 1);
    pulseClr();

    // R10: timeout during own transfer, SCL stretched by the bus
    drv(); toMode = 2'd1; bitPos = 4'd2; tbSclLow = 1;
    request();
    idle(100);
    bitPos = 4'd0;
    waitTimeout(3000, cyc);
    check(timeoutFlag == 1, "R6 mode1 timeout fires", timeoutFlag, 1);
    check(xferBusy == 0 && startReq == 0, "R10 transfer aborted", {xferBusy, startReq}, 0);
    busStop();
    pulseClr();

    // R3: foreign owner blocks, then STOP releases
    drv(); toMode = 2'd0;
    busStart();
    request();
    idle(60);
    @(negedge clk);
    check(sdaDrvLow == 0, "R3 no drive while bus in use", sdaDrvLow, 0);
    busStop();
    waitSclPulse(60, seen);
    check(seen, "R3 start after bus freed", seen, 1);
    busStop();

    // R3: SCL held low blocks
    drv(); tbSclLow = 1;
    request();
    idle(60);
    @(negedge clk);
    check(sdaDrvLow == 0, "R3 no drive while scl low", sdaDrvLow, 0);
    drv(); tbSclLow = 0;
    waitSclPulse(60, seen);
    check(seen, "R3 start after scl release", seen, 1);
    busStop();
    pulseClr();

    // R7: no timeout with mode 0
    busStart();
    request();
    idle(20000);
    @(negedge clk);
    check(timeoutFlag == 0 && startReq == 1, "R7 waits without timeout", {timeoutFlag, startReq}, 1);
    // R13: disable
    drv(); ctrlEn = 0;
    idle(2);
    @(negedge clk);
    check({busInUse, startReq, xferBusy, sdaDrvLow} == 4'd0, "R13 disable clears",
          {busInUse, startReq, xferBusy, sdaDrvLow}, 0);
    drv(); ctrlEn = 1; tbSdaLow = 0;
    idle(6);
    pulseClr();

    // R6 and R12: exact timeout lengths for modes 2 and 3
    drv(); ieTimeout = 1; toMode = 2'd2;
    busStart();
    request();
    waitTimeout(6000, cyc);
    check(cyc == (1 << 12) + 1, "R6 mode2 length", cyc, (1 << 12) + 1);
    @(negedge clk);
    check(irq == 1, "R12 irq from timeout", irq, 1);
    pulseClr();
    @(negedge clk);
    check(irq == 0, "R12 irq drops after clear", irq, 0);
    drv(); toMode = 2'd3;
    request();
    waitTimeout(20000, cyc);
    check(cyc == (1 << 14) + 1, "R6 mode3 length", cyc, (1 << 14) + 1);
    busStop();
    pulseClr();
    ieTimeout = 0;

    // R5: SDA pinned low without a START, request never confirmed
    drv(); tbSclLow = 1;
    idle(3);
    tbSdaLow = 1;
    idle(3);
    tbSclLow = 0;
    idle(6);
    check(busInUse == 0, "R2 sda change under low scl ignored", busInUse, 0);
    drv(); toMode = 2'd1;
    request();
    idle(200);
    @(negedge clk);
    check(sdaDrvLow == 1 && startReq == 1, "R5 unconfirmed start keeps request", {sdaDrvLow, startReq}, 3);
    waitTimeout(3000, cyc);
    check(timeoutFlag == 1, "R5 unconfirmed start times out", timeoutFlag, 1);
    @(negedge clk);
    check(startReq == 0 && sdaDrvLow == 0, "R6 lines released on timeout", {startReq, sdaDrvLow}, 0);
    drv(); tbSdaLow = 0;
    idle(6);

    summary();
    $finish;
  end
endmodule